// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address into a physical address, or into a paging request, one clock after the address is presented. The top four address bits pick one of sixteen segments. Each segment is either linear or paged, and software can change this at run time. A linear segment swaps the top nibble of the address for a programmable 4-bit base and passes the rest through unchanged. A paged segment does not resolve an address here. Instead it emits a request that carries the virtual page number and the in-page offset to a separate page-translation path.

Privilege shapes the result. In supervisor mode all sixteen segments can be reached. In user mode only segments 0 to A can be reached. An access to the first 8 KiB page faults in either mode, so that null dereferences are caught. Configuration arrives as word writes: one mode word and two words of base nibbles.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset all outputs are zero, every segment is paged and every base is zero.
- R2: The segment index is `xl_vaddr[31:28]`. For a linear segment `xl_valid` is 1 and `xl_paddr` = {base of that segment, `xl_vaddr[27:0]`}; otherwise `xl_paddr` is 0.
- R3: Configuration write with `cfg_addr`=0 loads the mode word from `cfg_wdata[15:0]`, where bit n set makes segment n linear and bit n clear makes it paged. `cfg_addr`=1 loads the bases of segments 0..7 and `cfg_addr`=2 loads those of segments 8..15. In both cases segment k of the word sits at bits 4k+3:4k.
- R4: A paged segment gives `xl_page_req`=1, `xl_vpn`=`xl_vaddr[31:13]` and `xl_offset`=`xl_vaddr[12:0]`, with `xl_valid`=0. `xl_vpn` and `xl_offset` are 0 whenever `xl_page_req` is 0.
- R5: With `xl_user`=1, any address in segments B to F gives `xl_fault`=1.
- R6: Any address below 0x00002000 gives `xl_fault`=1 in either mode, whatever the segment setup.
- R7: When `xl_fault` is 1, both `xl_valid` and `xl_page_req` are 0, and so are `xl_paddr`, `xl_vpn` and `xl_offset`. `xl_valid` and `xl_page_req` are never both 1.
- R8: A configuration write applies to translations presented from the next cycle on. A translation presented in the same cycle as the write uses the old settings.
- R9: Results appear on the clock edge after `xl_req`. A cycle without `xl_req` gives all outputs zero on the next edge.
- R10: With `xl_user`=0, segments B to F translate normally.
- R11: With segments F, E, C and B linear with bases 0x0, 0x8, 0x4 and 0xB, and all other segments paged, address 0xC0001234 maps to 0x40001234.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Selects the word to write: 0 mode, 1 low bases, 2 high bases |
| cfg_wdata | input | 32 | Configuration write data |
| xl_req | input | 1 | A translation is presented this cycle |
| xl_user | input | 1 | 1 = user privilege, 0 = supervisor |
| xl_vaddr | input | 32 | Virtual address |
| xl_valid | output | 1 | Linear translation result is valid |
| xl_paddr | output | 32 | Physical address for a linear segment |
| xl_page_req | output | 1 | Request to the page-translation path |
| xl_vpn | output | 19 | Virtual page number of the request |
| xl_offset | output | 13 | Offset within the 8 KiB page |
| xl_fault | output | 1 | Access fault (null page or user privilege) |

## Verification
Every translation result is due exactly one rising edge after the cycle in which `xl_req` and the address are driven. The bench drives inputs on the falling edge. On the next falling edge it compares all six outputs with the expectation it computed for the previous stimulus. A configuration write updates the bench's model only after the expectation for the translation in the same cycle has been formed. This mirrors the one-cycle rule for the point at which a write takes effect.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    CFG_MODE    = 2'd0,
    CFG_BASE_LO = 2'd1,
    CFG_BASE_HI = 2'd2
  } cfg_word_e;
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs #(
  parameter int NSEG   = 16,
  parameter int SEG_W  = 4,
  parameter int CFG_W  = 32,
  parameter int CFG_AW = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]      cfg_wdata,
  output logic [NSEG-1:0]       lin_mask,
  output logic [NSEG*SEG_W-1:0] base_flat
);
  localparam int PER_WORD = CFG_W / SEG_W;

  always_ff @(posedge clk) begin
    if (rst) lin_mask <= '0;
    else if (cfg_we && cfg_addr == CFG_AW'(seg_xlate_pkg::CFG_MODE))
      lin_mask <= cfg_wdata[NSEG-1:0];
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_base
    localparam int WORD = i / PER_WORD;
    localparam int LANE = i % PER_WORD;
    always_ff @(posedge clk) begin
      if (rst) base_flat[i*SEG_W +: SEG_W] <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(1 + WORD))
        base_flat[i*SEG_W +: SEG_W] <= cfg_wdata[LANE*SEG_W +: SEG_W];
    end
  end
endmodule

// File: rtl/seg_classify.sv
module seg_classify #(
  parameter int ADDR_W    = 32,
  parameter int SEG_W     = 4,
  parameter int PAGE_W    = 13,
  parameter int USER_SEGS = 11
) (
  input  logic                          req,
  input  logic                          user,
  input  logic [ADDR_W-1:0]             vaddr,
  input  logic [(1<<SEG_W)-1:0]         lin_mask,
  input  logic [(1<<SEG_W)*SEG_W-1:0]   base_flat,
  output logic                          n_valid,
  output logic                          n_page_req,
  output logic                          n_fault,
  output logic [ADDR_W-1:0]             n_paddr,
  output logic [ADDR_W-PAGE_W-1:0]      n_vpn,
  output logic [PAGE_W-1:0]             n_offset
);
  localparam int VPN_W = ADDR_W - PAGE_W;

  logic [SEG_W-1:0] seg;
  logic [SEG_W-1:0] base;
  logic             is_lin, null_hit, priv_hit;

  always_comb begin
    seg      = vaddr[ADDR_W-1 -: SEG_W];
    is_lin   = lin_mask[seg];
    base     = base_flat[seg*SEG_W +: SEG_W];
    null_hit = (vaddr[ADDR_W-1:PAGE_W] == '0);
    priv_hit = user && (seg >= SEG_W'(USER_SEGS));

    n_fault    = req && (null_hit || priv_hit);
    n_valid    = req && !n_fault && is_lin;
    n_page_req = req && !n_fault && !is_lin;

    n_paddr  = n_valid ? {base, vaddr[ADDR_W-SEG_W-1:0]} : '0;
    n_vpn    = n_page_req ? vaddr[ADDR_W-1:PAGE_W] : VPN_W'(0);
    n_offset = n_page_req ? vaddr[PAGE_W-1:0] : '0;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int ADDR_W    = 32,
  parameter int SEG_W     = 4,
  parameter int PAGE_W    = 13,
  parameter int USER_SEGS = 11,
  parameter int CFG_W     = 32,
  parameter int CFG_AW    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic                     xl_req,
  input  logic                     xl_user,
  input  logic [ADDR_W-1:0]        xl_vaddr,
  output logic                     xl_valid,
  output logic [ADDR_W-1:0]        xl_paddr,
  output logic                     xl_page_req,
  output logic [ADDR_W-PAGE_W-1:0] xl_vpn,
  output logic [PAGE_W-1:0]        xl_offset,
  output logic                     xl_fault
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int VPN_W = ADDR_W - PAGE_W;

  logic [NSEG-1:0]       lin_mask;
  logic [NSEG*SEG_W-1:0] base_flat;
  logic                  n_valid, n_page_req, n_fault;
  logic [ADDR_W-1:0]     n_paddr;
  logic [VPN_W-1:0]      n_vpn;
  logic [PAGE_W-1:0]     n_offset;

  seg_cfg_regs #(.NSEG(NSEG), .SEG_W(SEG_W), .CFG_W(CFG_W), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lin_mask(lin_mask), .base_flat(base_flat)
  );

  seg_classify #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .PAGE_W(PAGE_W),
                 .USER_SEGS(USER_SEGS)) u_cls (
    .req(xl_req), .user(xl_user), .vaddr(xl_vaddr),
    .lin_mask(lin_mask), .base_flat(base_flat),
    .n_valid(n_valid), .n_page_req(n_page_req), .n_fault(n_fault),
    .n_paddr(n_paddr), .n_vpn(n_vpn), .n_offset(n_offset)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_valid    <= 1'b0;
      xl_page_req <= 1'b0;
      xl_fault    <= 1'b0;
      xl_paddr    <= '0;
      xl_vpn      <= '0;
      xl_offset   <= '0;
    end else begin
      xl_valid    <= n_valid;
      xl_page_req <= n_page_req;
      xl_fault    <= n_fault;
      xl_paddr    <= n_paddr;
      xl_vpn      <= n_vpn;
      xl_offset   <= n_offset;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W    = 32,
  parameter int SEG_W     = 4,
  parameter int PAGE_W    = 13,
  parameter int USER_SEGS = 11
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     xl_req,
  input logic                     xl_user,
  input logic [ADDR_W-1:0]        xl_vaddr,
  input logic                     xl_valid,
  input logic [ADDR_W-1:0]        xl_paddr,
  input logic                     xl_page_req,
  input logic [ADDR_W-PAGE_W-1:0] xl_vpn,
  input logic                     xl_fault
);
  assert_fault_excl_R7: assert property (@(posedge clk) disable iff (rst)
    xl_fault |-> (!xl_valid && !xl_page_req));

  assert_one_result_R7: assert property (@(posedge clk) disable iff (rst)
    $countones({xl_valid, xl_page_req, xl_fault}) <= 1);

  assert_user_block_R5: assert property (@(posedge clk) disable iff (rst)
    (xl_req && xl_user && xl_vaddr[ADDR_W-1 -: SEG_W] >= SEG_W'(USER_SEGS)) |=> xl_fault);

  assert_null_page_R6: assert property (@(posedge clk) disable iff (rst)
    (xl_req && xl_vaddr[ADDR_W-1:PAGE_W] == '0) |=> xl_fault);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !xl_req |=> (!xl_valid && !xl_page_req && !xl_fault));

  assert_low_bits_R2: assert property (@(posedge clk) disable iff (rst)
    xl_valid |-> (xl_paddr[ADDR_W-SEG_W-1:0] == $past(xl_vaddr[ADDR_W-SEG_W-1:0])));

  assert_vpn_pass_R4: assert property (@(posedge clk) disable iff (rst)
    xl_page_req |-> (xl_vpn == $past(xl_vaddr[ADDR_W-1:PAGE_W])));
endmodule

bind seg_xlate_unit seg_xlate_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .PAGE_W(PAGE_W),
                                    .USER_SEGS(USER_SEGS)) u_chk (.*);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        xl_req = 1'b0;
  logic        xl_user = 1'b0;
  logic [31:0] xl_vaddr = '0;
  logic        xl_valid, xl_page_req, xl_fault;
  logic [31:0] xl_paddr;
  logic [18:0] xl_vpn;
  logic [12:0] xl_offset;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  bit [15:0] m_mode = '0;
  bit [3:0]  m_base [16];
  bit        e_valid, e_page, e_fault;
  bit [31:0] e_paddr;
  bit [18:0] e_vpn;
  bit [12:0] e_off;
  string     e_tag = "R1";

  always #10 clk = ~clk;

  seg_xlate_unit i_seg_xlate_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .xl_req(xl_req), .xl_user(xl_user), .xl_vaddr(xl_vaddr),
    .xl_valid(xl_valid), .xl_paddr(xl_paddr), .xl_page_req(xl_page_req),
    .xl_vpn(xl_vpn), .xl_offset(xl_offset), .xl_fault(xl_fault)
  );

  task automatic compare();
    checks++;
    if (xl_valid !== e_valid || xl_page_req !== e_page || xl_fault !== e_fault ||
        xl_paddr !== e_paddr || xl_vpn !== e_vpn || xl_offset !== e_off) begin
      errors++;
      $display("FAIL %s: got v=%0b p=%0b f=%0b pa=%h vpn=%h off=%h exp v=%0b p=%0b f=%0b pa=%h vpn=%h off=%h",
               e_tag, xl_valid, xl_page_req, xl_fault, xl_paddr, xl_vpn, xl_offset,
               e_valid, e_page, e_fault, e_paddr, e_vpn, e_off);
    end
  endtask

  task automatic predict(input bit req, input bit user, input bit [31:0] va);
    int seg;
    bit lin;
    seg = int'(va >> 28);
    lin = m_mode[seg];
    e_valid = 0; e_page = 0; e_fault = 0; e_paddr = 0; e_vpn = 0; e_off = 0;
    if (req) begin
      if (va < 32'h2000 || (user && seg > 10)) e_fault = 1;
      else if (lin) begin
        e_valid = 1;
        e_paddr = (32'(m_base[seg]) << 28) | (va & 32'h0FFF_FFFF);
      end else begin
        e_page = 1;
        e_vpn  = 19'(va >> 13);
        e_off  = 13'(va % 8192);
      end
    end
  endtask

  task automatic model_write(input bit [1:0] sel, input bit [31:0] wd);
    if (sel == 2'd0) m_mode = wd[15:0];
    else if (sel == 2'd1 || sel == 2'd2)
      for (int k = 0; k < 8; k++) m_base[(sel == 2'd2 ? 8 : 0) + k] = 4'((wd >> (4 * k)) & 15);
  endtask

  task automatic step(input bit req, input bit user, input bit [31:0] va,
                      input bit we, input bit [1:0] sel, input bit [31:0] wd,
                      input string tag);
    @(negedge clk);
    compare();
    xl_req = req; xl_user = user; xl_vaddr = va;
    cfg_we = we; cfg_addr = sel; cfg_wdata = wd;
    predict(req, user, va);
    if (we) model_write(sel, wd);
    e_tag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) m_base[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state observed at first compare; defaults are paged
    step(1, 0, 32'hC000_1234, 0, 0, 0, "R1");
    // R8: mode write with a same-cycle translation uses old (paged) setting
    step(1, 0, 32'hC000_1234, 1, 0, 32'h0000_D800, "R8");
    // R8: high bases written; mode already linear but base still zero
    step(1, 0, 32'hC000_1234, 1, 2, 32'h0804_B000, "R8");
    // R11: reference layout
    step(1, 0, 32'hC000_1234, 0, 0, 0, "R11");
    step(1, 0, 32'hB000_0010, 0, 0, 0, "R10");
    step(1, 0, 32'hF123_4567, 0, 0, 0, "R2");
    step(1, 0, 32'hE000_0000, 0, 0, 0, "R2");
    step(1, 0, 32'hD004_000C, 0, 0, 0, "R4");
    step(1, 1, 32'hB000_0010, 0, 0, 0, "R5");
    step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, "R5");
    step(1, 1, 32'hAFFF_FFFC, 0, 0, 0, "R4");
    step(1, 1, 32'h0000_1FFF, 0, 0, 0, "R6");
    step(1, 0, 32'h0000_0000, 0, 0, 0, "R6");
    step(1, 0, 32'h0000_2000, 0, 0, 0, "R4");
    // R3: low base word and extra mode bits
    step(0, 0, 0, 1, 1, 32'h9ABC_DEF1, "R9");
    step(0, 0, 0, 1, 0, 32'h0000_D811, "R9");
    step(1, 0, 32'h4000_0100, 0, 0, 0, "R3");
    step(1, 0, 32'h0FFF_FFFF, 0, 0, 0, "R3");
    step(1, 0, 32'h0000_0004, 0, 0, 0, "R7");
    step(1, 1, 32'h0000_0004, 0, 0, 0, "R7");
    step(0, 1, 32'hC000_0000, 0, 0, 0, "R9");
    // R10 / R5: sweep every segment in both privilege modes
    for (int s = 0; s < 16; s++)
      for (int u = 0; u < 2; u++)
        step(1, u[0], {s[3:0], 28'h0ABC_DE0}, 0, 0, 0, (u == 1) ? "R5" : "R10");
    step(0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule